// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers interrupt events from a parameterized set of sources (18 by default) and decides, every cycle, whether the processor should be diverted and to which entry address. Each source owns a sticky event flag, an individual enable and a level-select bit. Source 0 is a fixed source with no level-select bit and always counts as high level. A level input `prio_mode` chooses between two-level operation and single-level legacy operation.

In two-level mode, high-level sources are gated by the high global enable and divert to 0x000008. Low-level sources are gated by the low global enable and divert to 0x000018. A high-level request may interrupt a running low-level handler. A low-level request never interrupts a high-level handler. When the processor accepts a request (`irq_ack`), the block clears the global enable of that level and marks the level as in service. A return (`irq_ret`) closes the most recently entered level and sets its global enable again. Flags are cleared only by software. A source that is still flagged and enabled therefore requests again after the return.

All ports are plain control pins. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every flag, enable and both global enables are 0, all level-select bits are 1 (high), no level is in service, `irq_req` is 0 and `irq_vec` is 0.
- R2: A 1 on bit i of `src_evt` at a clock edge sets flag i. The flag stays set until a `flag_clr_wr` write with bit i of `flag_clr_mask` set. When set and clear hit the same flag in the same cycle, set wins.
- R3: A source can request only when its flag and its enable are both 1 and the global enable of its level is 1. Clearing the enable bit with an `en_wr` write masks that source.
- R4: With `prio_mode`=1, a source whose level bit is 1 is gated by `gie_val[1]` state and gives `irq_vec`=0x000008. A source whose level bit is 0 is gated by `gie_val[0]` state and gives `irq_vec`=0x000018.
- R5: Source 0 is always high level. A `pri_wr` write of 0 to bit 0 has no effect on where it vectors.
- R6: With `prio_mode`=0, level bits are ignored. The high global enable (bit 1) alone gates every source, and every request gives 0x000008.
- R7: `irq_ack` while `irq_req`=1 clears the global enable of the level being taken and marks that level in service. `irq_ack` while `irq_req`=0 has no effect.
- R8: While a low-level handler is in service, a pending high-level request is raised. While a high-level handler is in service, no low-level request is raised.
- R9: `irq_ret` ends the high level if it is in service, otherwise the low level. It sets that level's global enable again. With no level in service, `irq_ret` is ignored.
- R10: When both levels could request at once, the high level wins and `irq_vec` is 0x000008. `irq_vec` is 0 whenever `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prio_mode | input | 1 | 1 = two-level operation, 0 = single-level legacy |
| src_evt | input | 18 | Per-source event pulses that set the flags |
| flag_clr_wr | input | 1 | Strobe for clearing flags |
| flag_clr_mask | input | 18 | Flags to clear when `flag_clr_wr` is 1 |
| en_wr | input | 1 | Strobe for writing the enable bits |
| en_val | input | 18 | New enable bits |
| pri_wr | input | 1 | Strobe for writing the level-select bits |
| pri_val | input | 18 | New level-select bits, 1 = high (bit 0 ignored) |
| gie_wr | input | 1 | Strobe for writing the global enables |
| gie_val | input | 2 | [1] = high/global enable, [0] = low enable |
| irq_ack | input | 1 | Processor accepts the current request |
| irq_ret | input | 1 | Processor returns from a handler |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 21 | Entry address of the request |

## Verification
All state is registered at the clock edge and the outputs are decoded combinationally from it. A write, event, acknowledge or return applied before an edge therefore shows on `irq_req` and `irq_vec` right after that edge, with one cycle of latency. A change on `prio_mode` shows within the same cycle. The bench drives every stimulus on the falling edge, lets one rising edge pass, and compares both outputs on the following falling edge against a model stepped at that same rising edge. This matches the one-cycle latency exactly, and no check samples near an edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int NUM_SRC   = 18;
  parameter int VEC_W     = 21;
  parameter int FIXED_IDX = 0;
  parameter logic [VEC_W-1:0] HI_VEC = 21'h000008;
  parameter logic [VEC_W-1:0] LO_VEC = 21'h000018;

  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} irq_lvl_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N     = 18,
  parameter int FIXED = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_evt,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic         en_wr,
  input  logic [N-1:0] en_val,
  input  logic         pri_wr,
  input  logic [N-1:0] pri_val,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] en_q,
  output logic [N-1:0] pri_eff
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        if (src_evt[i])                flag_q[i] <= 1'b1;
        else if (clr_wr && clr_mask[i]) flag_q[i] <= 1'b0;
        if (en_wr) en_q[i] <= en_val[i];
      end
    end

    if (i == FIXED) begin : g_fixed
      assign pri_eff[i] = 1'b1;
    end else begin : g_prog
      logic pri_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pri_q <= 1'b1;
        else if (pri_wr) pri_q <= pri_val[i];
      end
      assign pri_eff[i] = pri_q;
    end
  end

  logic unused_pri_bit;
  assign unused_pri_bit = pri_val[FIXED];
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N     = 18,
  parameter int VEC_W = 21,
  parameter logic [VEC_W-1:0] HI_VEC = 21'h000008,
  parameter logic [VEC_W-1:0] LO_VEC = 21'h000018
) (
  input  logic [N-1:0]     flag_q,
  input  logic [N-1:0]     en_q,
  input  logic [N-1:0]     pri_eff,
  input  logic             prio_mode,
  input  logic             gie_hi,
  input  logic             gie_lo,
  input  logic             hi_act,
  output logic             req,
  output logic             take_hi,
  output logic [VEC_W-1:0] vec
);
  logic [N-1:0] live;
  logic [N-1:0] hi_mask;
  logic         pend_hi, pend_lo, req_hi, req_lo;

  always_comb begin
    live    = flag_q & en_q;
    hi_mask = prio_mode ? pri_eff : {N{1'b1}};
    pend_hi = |(live & hi_mask);
    pend_lo = prio_mode & (|(live & ~pri_eff));
    req_hi  = pend_hi & gie_hi;
    req_lo  = pend_lo & gie_lo & ~hi_act;
    req     = req_hi | req_lo;
    take_hi = req_hi;
    if (req_hi)      vec = HI_VEC;
    else if (req_lo) vec = LO_VEC;
    else             vec = '0;
  end
endmodule

// File: rtl/irq_level_ctl.sv
module irq_level_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gie_wr,
  input  logic [1:0] gie_val,
  input  logic       enter,
  input  logic       enter_hi,
  input  logic       ret,
  output logic       gie_hi,
  output logic       gie_lo,
  output logic       hi_act
);
  logic lo_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_hi <= 1'b0;
      gie_lo <= 1'b0;
      hi_act <= 1'b0;
      lo_act <= 1'b0;
    end else begin
      if (gie_wr) begin
        gie_hi <= gie_val[1];
        gie_lo <= gie_val[0];
      end
      if (enter) begin
        if (enter_hi) begin
          gie_hi <= 1'b0;
          hi_act <= 1'b1;
        end else begin
          gie_lo <= 1'b0;
          lo_act <= 1'b1;
        end
      end else if (ret) begin
        if (hi_act) begin
          hi_act <= 1'b0;
          gie_hi <= 1'b1;
        end else if (lo_act) begin
          lo_act <= 1'b0;
          gie_lo <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int VW   = VEC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prio_mode,
  input  logic [NSRC-1:0] src_evt,
  input  logic            flag_clr_wr,
  input  logic [NSRC-1:0] flag_clr_mask,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_val,
  input  logic            pri_wr,
  input  logic [NSRC-1:0] pri_val,
  input  logic            gie_wr,
  input  logic [1:0]      gie_val,
  input  logic            irq_ack,
  input  logic            irq_ret,
  output logic            irq_req,
  output logic [VW-1:0]   irq_vec
);
  logic [NSRC-1:0] flag_q, en_q, pri_eff;
  logic gie_hi, gie_lo, hi_act, take_hi;

  irq_src_bank #(.N(NSRC), .FIXED(FIXED_IDX)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .clr_wr(flag_clr_wr), .clr_mask(flag_clr_mask),
    .en_wr(en_wr), .en_val(en_val), .pri_wr(pri_wr), .pri_val(pri_val),
    .flag_q(flag_q), .en_q(en_q), .pri_eff(pri_eff)
  );

  irq_arbiter #(.N(NSRC), .VEC_W(VW),
                .HI_VEC(VW'(HI_VEC)), .LO_VEC(VW'(LO_VEC))) u_arb (
    .flag_q(flag_q), .en_q(en_q), .pri_eff(pri_eff), .prio_mode(prio_mode),
    .gie_hi(gie_hi), .gie_lo(gie_lo), .hi_act(hi_act),
    .req(irq_req), .take_hi(take_hi), .vec(irq_vec)
  );

  irq_level_ctl u_lvl (
    .clk(clk), .rst_n(rst_n), .gie_wr(gie_wr), .gie_val(gie_val),
    .enter(irq_ack & irq_req), .enter_hi(take_hi), .ret(irq_ret),
    .gie_hi(gie_hi), .gie_lo(gie_lo), .hi_act(hi_act)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NSRC = 18,
  parameter int VW   = 21
) (
  input logic            clk,
  input logic            rst_n,
  input logic            prio_mode,
  input logic            irq_req,
  input logic [VW-1:0]   irq_vec,
  input logic            irq_ack,
  input logic            irq_ret,
  input logic            gie_wr,
  input logic [NSRC-1:0] flag_q,
  input logic [NSRC-1:0] en_q,
  input logic            hi_act
);
  localparam logic [VW-1:0] V_HI = VW'(24'h000008);
  localparam logic [VW-1:0] V_LO = VW'(24'h000018);

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec == V_HI || irq_vec == V_LO)); // R4
  AST_LEGACY_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (!prio_mode && irq_req) |-> irq_vec == V_HI); // R6
  AST_NEED_LIVE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & en_q) == '0) |-> !irq_req); // R3
  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == V_HI && !gie_wr && !irq_ret) |=> !irq_req); // R7
  AST_LO_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_act && irq_req) |-> irq_vec == V_HI); // R8
  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vec == '0); // R10
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode), .irq_req(irq_req),
  .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret), .gie_wr(gie_wr),
  .flag_q(flag_q), .en_q(en_q), .hi_act(hi_act)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  localparam int N = 18;
  localparam int W = 21;

  logic clk = 0, rst_n = 0;
  logic mode = 0, clr_wr = 0, en_wr = 0, pri_wr = 0, gie_wr = 0, ack = 0, ret = 0;
  logic [N-1:0] evt = '0, clr = '0, en_v = '0, pri_v = '0;
  logic [1:0] gie_v = '0;
  logic irq_req;
  logic [W-1:0] irq_vec;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [N-1:0] m_flag, m_en, m_pri;
  logic m_gh, m_gl, m_ha, m_la;

  always #2.5 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .prio_mode(mode), .src_evt(evt),
    .flag_clr_wr(clr_wr), .flag_clr_mask(clr), .en_wr(en_wr), .en_val(en_v),
    .pri_wr(pri_wr), .pri_val(pri_v), .gie_wr(gie_wr), .gie_val(gie_v),
    .irq_ack(ack), .irq_ret(ret), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic logic [N-1:0] eff_pri(input logic [N-1:0] p);
    return p | {{(N-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic exp_hi();
    logic [N-1:0] live = m_flag & m_en;
    if (!mode) return m_gh && (live != '0);
    return m_gh && ((live & eff_pri(m_pri)) != '0);
  endfunction

  function automatic logic exp_lo();
    logic [N-1:0] live = m_flag & m_en;
    return mode && m_gl && !m_ha && ((live & ~eff_pri(m_pri)) != '0);
  endfunction

  function automatic logic [W-1:0] exp_vec();
    if (exp_hi()) return 21'h000008;
    if (exp_lo()) return 21'h000018;
    return '0;
  endfunction

  task automatic model_edge();
    logic take = ack && (exp_hi() || exp_lo());
    logic th = exp_hi();
    for (int i = 0; i < N; i++) begin
      if (evt[i]) m_flag[i] = 1'b1;
      else if (clr_wr && clr[i]) m_flag[i] = 1'b0;
    end
    if (en_wr) m_en = en_v;
    if (pri_wr) m_pri = pri_v;
    if (gie_wr) begin m_gh = gie_v[1]; m_gl = gie_v[0]; end
    if (take) begin
      if (th) begin m_gh = 0; m_ha = 1; end
      else begin m_gl = 0; m_la = 1; end
    end else if (ret) begin
      if (m_ha) begin m_ha = 0; m_gh = 1; end
      else if (m_la) begin m_la = 0; m_gl = 1; end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (irq_req !== (exp_hi() || exp_lo()) || irq_vec !== exp_vec()) begin
      errors++;
      $display("FAIL %s: req=%0b vec=%h expected req=%0b vec=%h", tag,
               irq_req, irq_vec, exp_hi() || exp_lo(), exp_vec());
    end
  endtask

  // called at a negedge with inputs already set; compares at the next negedge
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    evt = '0; clr_wr = 0; clr = '0; en_wr = 0; pri_wr = 0; gie_wr = 0; ack = 0; ret = 0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag); step(tag); endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_flag = '0; m_en = '0; m_pri = '1; m_gh = 0; m_gl = 0; m_ha = 0; m_la = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset");

    // R1: level bits reset to high -> flagged src 3 vectors high in two-level mode
    mode = 1;
    en_wr = 1; en_v = 18'h00028; gie_wr = 1; gie_v = 2'b11; step("R1 cfg");
    evt[3] = 1; step("R1 reset level is high");
    ack = 1; step("R7 high entry");
    ret = 1; step("R9 return re-requests");
    clr_wr = 1; clr[3] = 1; step("R2 clear flag");

    // R4 low level source
    pri_wr = 1; pri_v = ~18'h00008; step("R4 cfg");
    evt[3] = 1; step("R4 low vector");
    ack = 1; step("R7 low entry");
    evt[5] = 1; step("R8 high preempts low");
    ack = 1; step("R7 high entry nested");
    ret = 1; step("R9 return high first");
    clr_wr = 1; clr[5] = 1; step("R9 still in low handler");
    ret = 1; step("R9 low re-request");
    evt[5] = 1; step("R10 high wins");
    ack = 1; step("R8 low blocked in high handler");
    ret = 1; step("R9 ret");
    ack = 0; ret = 1; step("R9 no-op");
    ret = 1; step("R9 ret idle ignored");
    clr_wr = 1; clr = '1; step("R2 clear all");
    ack = 1; step("R7 ack idle ignored");

    // R2 set beats clear
    evt[5] = 1; clr_wr = 1; clr[5] = 1; step("R2 set wins");
    // R3 enable masks
    en_wr = 1; en_v = 18'h00008; step("R3 masked by enable");
    gie_wr = 1; gie_v = 2'b10; evt[3] = 1; step("R3 low gie off");
    // R5 fixed source
    en_wr = 1; en_v = 18'h00001; pri_wr = 1; pri_v = '0; evt[0] = 1; step("R5 fixed high");
    gie_wr = 1; gie_v = 2'b01; step("R5 fixed gated by high gie");
    // R6 legacy
    mode = 0; en_wr = 1; en_v = 18'h00008; gie_wr = 1; gie_v = 2'b10; step("R6 legacy vec");
    ack = 1; step("R6 legacy entry");
    ret = 1; step("R6 legacy return");
    gie_wr = 1; gie_v = 2'b01; step("R6 low gie ignored");

    // random phase
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0: evt = N'($urandom) & N'($urandom);
        1: begin clr_wr = 1; clr = N'($urandom); end
        2: begin en_wr = 1; en_v = N'($urandom); end
        3: begin pri_wr = 1; pri_v = N'($urandom); end
        4: begin gie_wr = 1; gie_v = 2'($urandom); end
        5, 6: ack = 1;
        7: ret = 1;
        8: if ($urandom_range(0, 7) == 0) mode = ~mode;
        default: ;
      endcase
      step("R3/R4/R6/R8/R9 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule